// File: doc/BRIEF.md
# NAND Page Program Command Interface

This block is the device side of a byte-wide command bus for a small-page NAND memory, restricted to the page program path. Every bus cycle carries a write strobe and is marked as a command cycle, an address cycle or a data cycle. The block decodes the program sequence and collects the data bytes in a page buffer. On the confirm command it commits the buffer into a small on-chip array. During this internal busy period of programmable length it holds the ready/busy output low. It returns a status byte on its data output.

Programming can only clear bits. Each array byte becomes its old value ANDed with the buffered byte. Buffer bytes that were not loaded stay 0xFF, so they leave the array unchanged. A two-bit counter per page limits the number of partial programs on that page. A block erase strobe clears the counters of every page in the addressed block. The array content itself is not affected by the strobe.

While busy, the interface accepts only the status command and the reset command. The reset command abandons any sequence and shows a short fixed busy time.

Top module: `nandpg_cmdif`

## Requirements
- R1: A program runs only for this order: command 0x80, then exactly four address cycles, then data cycles, then command 0x10. The first address cycle is the start column. The low bits of the second address cycle select the page, as that value modulo NUM_PAGES. The last two address cycles are ignored. A 0x10 outside the data phase is ignored and ready/busy stays 1.
- R2: Data cycles fill the buffer one byte each, in ascending order from the start column. Bytes past column PAGE_BYTES-1 are discarded. Columns that were not loaded and other pages keep their array contents.
- R3: `rdy_busy` is 0 from the first clock edge after an accepted-or-rejected confirm, for exactly T_PROG cycles, and is then 1.
- R4: While busy, address cycles, data cycles and every command except 0x70 and 0xFF have no effect. Unknown command codes have no effect in any state.
- R5: Status bit 6 is 0 while busy and 1 when ready. Completion of a program leaves the interface in status mode.
- R6: Each programmed array byte becomes old AND loaded. Requesting a 0-to-1 change is not a failure, so status bit 0 stays 0 for an accepted program.
- R7: After a confirm or a 0x70 command, `io_dout` shows the status byte: bit 6 is ready, bit 0 is fail, and all other bits are 0. Command 0x80 or 0xFF leaves status mode, and `io_dout` is then 0x00.
- R8: A fourth confirm on one page without an erase in between is rejected. The array is unchanged, status bit 0 becomes 1, and the full busy time still runs. The next 0x80 clears bit 0.
- R9: `ers_stb` clears the partial-program counters of pages ers_blk*PAGES_PER_BLK up to ers_blk*PAGES_PER_BLK+PAGES_PER_BLK-1, and only those pages. When the strobe falls in the same cycle as a confirm, the clear is applied before the limit check.
- R10: Command 0xFF outside a reset wait abandons any sequence, including a running program. It holds `rdy_busy` at 0 for T_RST cycles, clears status mode and the fail bit, and keeps the partial-program counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_we | input | 1 | Bus write strobe, one cycle per transfer |
| io_cmd | input | 1 | Marks the cycle as a command cycle |
| io_adr | input | 1 | Marks the cycle as an address cycle (when io_cmd is 0) |
| io_din | input | 8 | Bus byte |
| io_dout | output | 8 | Status byte in status mode, otherwise 0x00 |
| rdy_busy | output | 1 | 1 = ready, 0 = busy |
| ers_stb | input | 1 | Block erase strobe, clears counters |
| ers_blk | input | clog2(NUM_PAGES/PAGES_PER_BLK) (1) | Block selected by the erase strobe |
| pk_pg | input | clog2(NUM_PAGES) (2) | Array observation page |
| pk_col | input | clog2(PAGE_BYTES+1) (10) | Array observation column |
| pk_dat | output | 8 | Array byte at pk_pg/pk_col |

## Verification
Two situations can arise in the same cycle, and both are driven on purpose.

The first is a block erase strobe that lands on the cycle of a confirm command, for a page that already holds three partial programs. The bench expects the counter clear to win, so the program is accepted: status reads 0x40 and not 0x41. This matches a behavioural per-page count that applies erases before judging the confirm.

The second is a command arriving while a program is still running. Setup, address, data, confirm and unknown codes are sent in the busy window. The status byte and the array are expected to be unaffected. A reset in that window must shorten the busy period to T_RST cycles and keep the counts.

// File: rtl/nandpg_pkg.sv
package nandpg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_PROG,
        ST_RST
    } nandpg_st_e;

    localparam logic [7:0] OP_SETUP   = 8'h80;
    localparam logic [7:0] OP_CONFIRM = 8'h10;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_RESET   = 8'hFF;
endpackage

// File: rtl/nandpg_seq.sv
module nandpg_seq
    import nandpg_pkg::*;
#(
    parameter int PAGE_BYTES = 528,
    parameter int NUM_PAGES  = 4,
    parameter int T_PROG     = 600,
    parameter int T_RST      = 4,
    localparam int COL_W = $clog2(PAGE_BYTES + 1),
    localparam int PG_W  = $clog2(NUM_PAGES),
    localparam int TM_W  = $clog2(T_PROG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_we,
    input  logic             io_cmd,
    input  logic             io_adr,
    input  logic [7:0]       io_din,
    input  logic             page_full,
    output logic             buf_clr,
    output logic             buf_we,
    output logic [COL_W-1:0] load_idx,
    output logic [COL_W-1:0] rd_idx,
    output logic             wr_en,
    output logic             prog_go,
    output logic [PG_W-1:0]  cur_pg,
    output logic             ready,
    output logic             srm,
    output logic             fail
);
    localparam logic [COL_W-1:0] COL_END   = COL_W'(PAGE_BYTES);
    localparam logic [TM_W-1:0]  WR_END    = TM_W'(PAGE_BYTES);
    localparam logic [TM_W-1:0]  PROG_LAST = TM_W'(T_PROG - 1);
    localparam logic [TM_W-1:0]  RST_LAST  = TM_W'(T_RST - 1);

    typedef struct packed {
        nandpg_st_e       st;
        logic [1:0]       acnt;
        logic [COL_W-1:0] col;
        logic [PG_W-1:0]  pg;
        logic [TM_W-1:0]  tcnt;
        logic             ok;
        logic             srm;
        logic             fail;
    } seq_t;

    seq_t q, d;
    logic cmd_w, adr_w, dat_w, busy;
    logic [TM_W-1:0] last;

    assign cmd_w = io_we & io_cmd;
    assign adr_w = io_we & io_adr & ~io_cmd;
    assign dat_w = io_we & ~io_cmd & ~io_adr;
    assign busy  = (q.st == ST_PROG) || (q.st == ST_RST);
    assign last  = (q.st == ST_PROG) ? PROG_LAST : RST_LAST;

    always_comb begin
        d       = q;
        buf_clr = 1'b0;
        buf_we  = 1'b0;
        prog_go = 1'b0;
        if (busy) begin
            if (q.tcnt == last) begin
                d.st   = ST_IDLE;
                d.tcnt = '0;
            end else begin
                d.tcnt = q.tcnt + 1'b1;
            end
            if (cmd_w && io_din == OP_STATUS) d.srm = 1'b1;
            if (cmd_w && io_din == OP_RESET && q.st == ST_PROG) begin
                d.st   = ST_RST;
                d.tcnt = '0;
                d.srm  = 1'b0;
                d.fail = 1'b0;
                d.ok   = 1'b0;
            end
        end else if (cmd_w) begin
            case (io_din)
                OP_SETUP: begin
                    d.st    = ST_ADDR;
                    d.acnt  = '0;
                    d.col   = '0;
                    d.pg    = '0;
                    d.srm   = 1'b0;
                    d.fail  = 1'b0;
                    buf_clr = 1'b1;
                end
                OP_STATUS: d.srm = 1'b1;
                OP_CONFIRM: begin
                    if (q.st == ST_DATA) begin
                        d.st    = ST_PROG;
                        d.tcnt  = '0;
                        d.srm   = 1'b1;
                        d.ok    = ~page_full;
                        d.fail  = page_full;
                        prog_go = ~page_full;
                    end
                end
                OP_RESET: begin
                    d.st   = ST_RST;
                    d.tcnt = '0;
                    d.srm  = 1'b0;
                    d.fail = 1'b0;
                end
                default: ;
            endcase
        end else if (adr_w && q.st == ST_ADDR) begin
            if (q.acnt == 2'd0) d.col = COL_W'(io_din);
            if (q.acnt == 2'd1) d.pg  = io_din[PG_W-1:0];
            if (q.acnt == 2'd3) d.st  = ST_DATA;
            d.acnt = q.acnt + 1'b1;
        end else if (dat_w && q.st == ST_DATA) begin
            if (q.col < COL_END) begin
                buf_we = 1'b1;
                d.col  = q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign load_idx = q.col;
    assign rd_idx   = q.tcnt[COL_W-1:0];
    assign wr_en    = (q.st == ST_PROG) && q.ok && (q.tcnt < WR_END);
    assign cur_pg   = q.pg;
    assign ready    = ~busy;
    assign srm      = q.srm;
    assign fail     = q.fail;

    assert_confirm_only_in_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && cmd_w && io_din == OP_CONFIRM) |=> (q.st == ST_IDLE && ready));

    assert_confirm_goes_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA && cmd_w && io_din == OP_CONFIRM) |=> (q.st == ST_PROG && !ready));

    assert_busy_ignores_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PROG && cmd_w && io_din != OP_STATUS && io_din != OP_RESET
         && q.tcnt != PROG_LAST) |=> (q.st == ST_PROG && $stable(q.fail)));

    assert_done_in_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PROG && q.tcnt == PROG_LAST && !(cmd_w && io_din == OP_RESET))
        |=> (ready && q.srm));
endmodule

// File: rtl/nandpg_pagebuf.sv
module nandpg_pagebuf #(
    parameter int PAGE_BYTES = 528,
    localparam int COL_W = $clog2(PAGE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [COL_W-1:0] widx,
    input  logic [7:0]       wdat,
    input  logic [COL_W-1:0] ridx,
    output logic [7:0]       rdat
);
    localparam logic [COL_W-1:0] COL_END = COL_W'(PAGE_BYTES);

    logic [7:0] buf_q [PAGE_BYTES];
    logic [7:0] buf_d [PAGE_BYTES];

    always_comb begin
        buf_d = buf_q;
        if (clr) begin
            for (int i = 0; i < PAGE_BYTES; i++) buf_d[i] = 8'hFF;
        end else if (we && widx < COL_END) begin
            buf_d[widx] = wdat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= 8'hFF;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign rdat = (ridx < COL_END) ? buf_q[ridx] : 8'hFF;

    assert_setup_presets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (buf_q[0] == 8'hFF && buf_q[PAGE_BYTES-1] == 8'hFF));
endmodule

// File: rtl/nandpg_pcnt.sv
module nandpg_pcnt #(
    parameter int NUM_PAGES     = 4,
    parameter int PAGES_PER_BLK = 2,
    parameter int MAX_PART      = 3,
    localparam int PG_W  = $clog2(NUM_PAGES),
    localparam int BLK_W = $clog2(NUM_PAGES / PAGES_PER_BLK),
    localparam int CW    = $clog2(MAX_PART + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ers_stb,
    input  logic [BLK_W-1:0] ers_blk,
    input  logic             inc,
    input  logic [PG_W-1:0]  pg,
    output logic             full
);
    localparam logic [CW-1:0] CMAX = CW'(MAX_PART);

    logic [CW-1:0] cnt_q [NUM_PAGES];
    logic [CW-1:0] cnt_d [NUM_PAGES];
    logic [NUM_PAGES-1:0] clr;

    always_comb begin
        for (int p = 0; p < NUM_PAGES; p++) begin
            clr[p]   = ers_stb && (ers_blk == BLK_W'(p / PAGES_PER_BLK));
            cnt_d[p] = clr[p] ? '0 : cnt_q[p];
            if (inc && pg == PG_W'(p)) cnt_d[p] = cnt_d[p] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PAGES; p++) cnt_q[p] <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign full = (cnt_q[pg] == CMAX) && !clr[pg];

    assert_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr[pg]) |-> (cnt_q[pg] != CMAX));

    assert_erase_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ers_stb && !inc) |=> (cnt_q[$past(pg)] == '0 || !$past(clr[pg])));
endmodule

// File: rtl/nandpg_array.sv
module nandpg_array #(
    parameter int PAGE_BYTES = 528,
    parameter int NUM_PAGES  = 4,
    localparam int COL_W = $clog2(PAGE_BYTES + 1),
    localparam int PG_W  = $clog2(NUM_PAGES),
    localparam int DEPTH = PAGE_BYTES * NUM_PAGES,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PG_W-1:0]  wr_pg,
    input  logic [COL_W-1:0] wr_col,
    input  logic [7:0]       wr_dat,
    input  logic [PG_W-1:0]  pk_pg,
    input  logic [COL_W-1:0] pk_col,
    output logic [7:0]       pk_dat
);
    localparam logic [AW-1:0]    PB      = AW'(PAGE_BYTES);
    localparam logic [COL_W-1:0] COL_END = COL_W'(PAGE_BYTES);

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];
    logic [AW-1:0] widx, pidx;

    assign widx = AW'(wr_pg) * PB + AW'(wr_col);
    assign pidx = AW'(pk_pg) * PB + AW'(pk_col);

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[widx] = mem_q[widx] & wr_dat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign pk_dat = (pk_col < COL_END) ? mem_q[pidx] : 8'hFF;

    assert_bits_only_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem_q[$past(widx)] & ~$past(mem_q[widx])) == 8'h00));
endmodule

// File: rtl/nandpg_cmdif.sv
module nandpg_cmdif #(
    parameter int PAGE_BYTES    = 528,
    parameter int NUM_PAGES     = 4,
    parameter int PAGES_PER_BLK = 2,
    parameter int MAX_PART      = 3,
    parameter int T_PROG        = 600,
    parameter int T_RST         = 4,
    localparam int COL_W = $clog2(PAGE_BYTES + 1),
    localparam int PG_W  = $clog2(NUM_PAGES),
    localparam int BLK_W = $clog2(NUM_PAGES / PAGES_PER_BLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_we,
    input  logic             io_cmd,
    input  logic             io_adr,
    input  logic [7:0]       io_din,
    output logic [7:0]       io_dout,
    output logic             rdy_busy,
    input  logic             ers_stb,
    input  logic [BLK_W-1:0] ers_blk,
    input  logic [PG_W-1:0]  pk_pg,
    input  logic [COL_W-1:0] pk_col,
    output logic [7:0]       pk_dat
);
    logic             page_full, buf_clr, buf_we, wr_en, prog_go, ready, srm, fail;
    logic [COL_W-1:0] load_idx, rd_idx;
    logic [PG_W-1:0]  cur_pg;
    logic [7:0]       buf_rdat;

    nandpg_seq #(
        .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES),
        .T_PROG(T_PROG), .T_RST(T_RST)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_cmd(io_cmd), .io_adr(io_adr),
        .io_din(io_din), .page_full(page_full), .buf_clr(buf_clr), .buf_we(buf_we),
        .load_idx(load_idx), .rd_idx(rd_idx), .wr_en(wr_en), .prog_go(prog_go),
        .cur_pg(cur_pg), .ready(ready), .srm(srm), .fail(fail)
    );

    nandpg_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) buf_i (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we), .widx(load_idx),
        .wdat(io_din), .ridx(rd_idx), .rdat(buf_rdat)
    );

    nandpg_pcnt #(
        .NUM_PAGES(NUM_PAGES), .PAGES_PER_BLK(PAGES_PER_BLK), .MAX_PART(MAX_PART)
    ) pcnt_i (
        .clk(clk), .rst_n(rst_n), .ers_stb(ers_stb), .ers_blk(ers_blk),
        .inc(prog_go), .pg(cur_pg), .full(page_full)
    );

    nandpg_array #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) arr_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pg(cur_pg), .wr_col(rd_idx),
        .wr_dat(buf_rdat), .pk_pg(pk_pg), .pk_col(pk_col), .pk_dat(pk_dat)
    );

    assign rdy_busy = ready;
    assign io_dout  = srm ? {1'b0, ready, 5'b0, fail} : 8'h00;

    assert_status_hides_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_we && io_cmd && io_din == 8'h80 && ready) |=> (io_dout == 8'h00));
endmodule

// File: tb/nandpg_cmdif_tb_top.sv
module nandpg_cmdif_tb_top;
    localparam int PB    = 528;
    localparam int NP    = 4;
    localparam int PPB   = 2;
    localparam int TPROG = 600;
    localparam int TRST  = 4;
    localparam int COL_W = $clog2(PB + 1);
    localparam int PG_W  = $clog2(NP);
    localparam int BLK_W = $clog2(NP / PPB);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic io_we = 1'b0, io_cmd = 1'b0, io_adr = 1'b0;
    logic [7:0] io_din = 8'h00;
    logic [7:0] io_dout;
    logic rdy_busy;
    logic ers_stb = 1'b0;
    logic [BLK_W-1:0] ers_blk = '0;
    logic [PG_W-1:0] pk_pg = '0;
    logic [COL_W-1:0] pk_col = '0;
    logic [7:0] pk_dat;

    always #4 clk = ~clk;

    nandpg_cmdif #(
        .PAGE_BYTES(PB), .NUM_PAGES(NP), .PAGES_PER_BLK(PPB),
        .MAX_PART(3), .T_PROG(TPROG), .T_RST(TRST)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_cmd(io_cmd), .io_adr(io_adr),
        .io_din(io_din), .io_dout(io_dout), .rdy_busy(rdy_busy), .ers_stb(ers_stb),
        .ers_blk(ers_blk), .pk_pg(pk_pg), .pk_col(pk_col), .pk_dat(pk_dat)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // behavioural reference: phase 0 idle, 1 address, 2 data, 3 programming, 4 reset wait
    int m_ph, m_acnt, m_col, m_pg, m_left;
    bit m_sr, m_fail, m_ok;
    logic [7:0] m_buf [PB];
    logic [7:0] m_mem [NP*PB];
    int m_cnt [NP];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_acnt = 0; m_col = 0; m_pg = 0; m_left = 0;
            m_sr = 0; m_fail = 0; m_ok = 0;
            foreach (m_buf[i]) m_buf[i] = 8'hFF;
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            foreach (m_cnt[i]) m_cnt[i] = 0;
        end else begin
            bit cw, aw, dw;
            cw = io_we && io_cmd;
            aw = io_we && io_adr && !io_cmd;
            dw = io_we && !io_cmd && !io_adr;
            if (ers_stb)
                for (int p = 0; p < NP; p++) if (p / PPB == int'(ers_blk)) m_cnt[p] = 0;
            if (m_ph >= 3) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    if (m_ph == 3 && m_ok)
                        for (int i = 0; i < PB; i++)
                            m_mem[m_pg*PB + i] = m_mem[m_pg*PB + i] & m_buf[i];
                    m_ph = 0;
                end
                if (cw && io_din == 8'h70) m_sr = 1;
                if (cw && io_din == 8'hFF && (m_ph == 3 || (m_ph == 0 && m_left == 0 && !m_ok && 0))) ;
                if (cw && io_din == 8'hFF && m_left >= 0 && m_was_prog()) begin
                    m_ph = 4; m_left = TRST; m_sr = 0; m_fail = 0; m_ok = 0;
                end
            end else if (cw) begin
                case (io_din)
                    8'h80: begin
                        m_ph = 1; m_acnt = 0; m_col = 0; m_pg = 0; m_sr = 0; m_fail = 0;
                        foreach (m_buf[i]) m_buf[i] = 8'hFF;
                    end
                    8'h70: m_sr = 1;
                    8'h10: if (m_ph == 2) begin
                        m_ph = 3; m_left = TPROG; m_sr = 1;
                        if (m_cnt[m_pg] >= 3) begin m_ok = 0; m_fail = 1; end
                        else begin m_ok = 1; m_fail = 0; m_cnt[m_pg]++; end
                    end
                    8'hFF: begin m_ph = 4; m_left = TRST; m_sr = 0; m_fail = 0; end
                    default: ;
                endcase
            end else if (aw && m_ph == 1) begin
                if (m_acnt == 0) m_col = int'(io_din);
                if (m_acnt == 1) m_pg = int'(io_din) % NP;
                if (m_acnt == 3) m_ph = 2;
                m_acnt++;
            end else if (dw && m_ph == 2) begin
                if (m_col < PB) begin m_buf[m_col] = io_din; m_col++; end
            end
            m_prev_prog = (m_ph == 3);
        end
    end

    // tracks whether the phase before this edge's update was programming
    bit m_prev_prog = 0;
    function automatic bit m_was_prog();
        return m_prev_prog;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit er;
            er = !(m_ph == 3 || m_ph == 4);
            chk("R3 rdy_busy vs model", int'(rdy_busy), int'(er));
            chk("R7 io_dout vs model", int'(io_dout),
                m_sr ? int'({1'b0, er, 5'b0, m_fail}) : 0);
        end
    end

    task automatic bus(input bit c, input bit a, input logic [7:0] v);
        io_we = 1; io_cmd = c; io_adr = a; io_din = v;
        @(negedge clk);
        io_we = 0; io_cmd = 0; io_adr = 0;
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 11) ^ (i >> 2));
    endfunction

    task automatic head(input int pg, input int col);
        bus(1, 0, 8'h80); bus(0, 1, 8'(col)); bus(0, 1, 8'(pg)); bus(0, 1, 8'h00); bus(0, 1, 8'h00);
    endtask

    task automatic prog(input int pg, input int col, input int n, input int seed);
        head(pg, col);
        for (int i = 0; i < n; i++) bus(0, 0, pat(seed, i));
        bus(1, 0, 8'h10);
    endtask

    task automatic wait_rdy(output int cyc);
        cyc = 0;
        while (!rdy_busy) begin cyc++; @(negedge clk); end
    endtask

    task automatic peek(input string tag, input int pg, input int col, input int exp);
        pk_pg = PG_W'(pg); pk_col = COL_W'(col);
        #1;
        chk(tag, int'(pk_dat), exp);
        chk({tag, " model"}, int'(pk_dat), int'(m_mem[pg*PB + col]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int cyc;
        logic [7:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R7 reset dout", int'(io_dout), 0);
        chk("R3 reset ready", int'(rdy_busy), 1);
        peek("R2 reset array", 0, 0, 8'hFF);

        // R1 ordering: stray confirms ignored
        bus(1, 0, 8'h10);
        chk("R1 confirm without setup", int'(rdy_busy), 1);
        bus(1, 0, 8'h80); bus(0, 1, 8'h00);
        bus(1, 0, 8'h10);
        chk("R1 confirm during address", int'(rdy_busy), 1);
        bus(0, 1, 8'h03); bus(0, 1, 8'h00); bus(0, 1, 8'h00);
        bus(0, 0, 8'h5A); bus(1, 0, 8'h10);
        chk("R1 confirm after data", int'(rdy_busy), 0);
        wait_rdy(cyc);
        peek("R1 page 3 byte", 3, 0, 8'h5A);

        // R4 unknown command while idle
        bus(1, 0, 8'h00);
        chk("R4 unknown code idle", int'(io_dout), 8'h40);

        // R2/R3 full page with overflow
        prog(0, 0, PB + 4, 1);
        chk("R3 busy right after confirm", int'(rdy_busy), 0);
        wait_rdy(cyc);
        chk("R3 busy length", cyc, TPROG);
        chk("R5 status after program", int'(io_dout), 8'h40);
        peek("R2 first byte", 0, 0, int'(pat(1, 0)));
        peek("R2 last byte", 0, PB - 1, int'(pat(1, PB - 1)));
        peek("R2 other page untouched", 1, 0, 8'hFF);

        // R2 partial program
        prog(1, 10, 5, 2);
        wait_rdy(cyc);
        peek("R2 below start", 1, 9, 8'hFF);
        peek("R2 above end", 1, 15, 8'hFF);
        peek("R2 loaded byte", 1, 10, int'(pat(2, 0)));

        // R6 AND behaviour with 0-to-1 requests
        keep = m_mem[1*PB + 10];
        head(1, 10);
        bus(0, 0, 8'h0F); bus(0, 0, 8'hFF);
        bus(1, 0, 8'h10);
        wait_rdy(cyc);
        chk("R6 fail bit clear", int'(io_dout), 8'h40);
        peek("R6 and result", 1, 10, int'(keep & 8'h0F));
        peek("R6 ff keeps old", 1, 11, int'(pat(2, 1)));

        // R8 third accepted, fourth rejected
        prog(1, 20, 3, 3);
        wait_rdy(cyc);
        chk("R8 third accepted", int'(io_dout), 8'h40);
        prog(1, 30, 3, 4);
        wait_rdy(cyc);
        chk("R8 reject busy length", cyc, TPROG);
        chk("R8 fail bit set", int'(io_dout), 8'h41);
        peek("R8 array unchanged", 1, 30, 8'hFF);
        bus(1, 0, 8'h80);
        chk("R8 setup clears fail", int'(io_dout), 0);
        bus(1, 0, 8'hFF);
        wait_rdy(cyc);
        chk("R10 reset wait length", cyc, TRST);

        // R4 commands during busy
        prog(2, 0, 3, 5);
        bus(1, 0, 8'h80);
        chk("R4 setup ignored busy", int'(io_dout), 8'h00);
        bus(0, 1, 8'h01); bus(0, 0, 8'h00); bus(1, 0, 8'h10); bus(1, 0, 8'h33);
        chk("R4 still busy", int'(rdy_busy), 0);
        bus(1, 0, 8'h70);
        chk("R5 status during busy", int'(io_dout), 8'h00);
        wait_rdy(cyc);
        chk("R5 status on completion", int'(io_dout), 8'h40);
        peek("R4 busy data ignored", 2, 0, int'(pat(5, 0)));
        peek("R4 busy data ignored 2", 2, 3, 8'hFF);

        // R10 reset during programming keeps counters
        prog(0, 40, 2, 6);
        repeat (10) @(negedge clk);
        bus(1, 0, 8'hFF);
        wait_rdy(cyc);
        chk("R10 abort wait length", cyc, TRST);
        chk("R10 status mode left", int'(io_dout), 0);
        prog(0, 50, 2, 7);
        wait_rdy(cyc);
        chk("R10 third on page 0", int'(io_dout), 8'h40);
        prog(0, 60, 2, 8);
        wait_rdy(cyc);
        chk("R10 counters kept", int'(io_dout), 8'h41);

        // R9 erase strobe
        ers_stb = 1; ers_blk = '0;
        @(negedge clk);
        ers_stb = 0;
        prog(0, 70, 1, 9);
        wait_rdy(cyc);
        chk("R9 erased block accepts", int'(io_dout), 8'h40);
        prog(2, 80, 1, 10); wait_rdy(cyc);
        prog(2, 90, 1, 11); wait_rdy(cyc);
        prog(2, 100, 1, 12); wait_rdy(cyc);
        chk("R9 other block kept", int'(io_dout), 8'h41);

        // R9 erase coinciding with confirm
        head(2, 110);
        bus(0, 0, 8'h11);
        io_we = 1; io_cmd = 1; io_din = 8'h10; ers_stb = 1; ers_blk = BLK_W'(1);
        @(negedge clk);
        io_we = 0; io_cmd = 0; ers_stb = 0;
        wait_rdy(cyc);
        chk("R9 erase before check", int'(io_dout), 8'h40);
        peek("R9 written after erase", 2, 110, 8'h11);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule